// File: doc/BRIEF.md
# PWM Fault Trip Guard

This block sits between a PWM generator and four output pins grouped into two pairs. It watches three fault sources: two comparator trip lines and a fault pin that is active low. Any source that is enabled and trips forces the pins into their programmed safe states. The force acts through combinational logic, so it takes effect at once and does not wait for a clock edge.

A shutdown flag latches each trip. With auto-restart on, the flag clears by itself once the synchronised fault has gone. With auto-restart off, firmware clears the flag through the register port, and writes to the flag are refused while the fault is still present. After the flag clears, the pins stay in their safe states until the next PWM period-start pulse. Every PWM period therefore runs either entirely in shutdown or entirely with normal output.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset, both registers read 0 and every pin follows its PWM input with output enable high.
- R2: Only sources enabled in config bits [2:0] can trip. Bit 0 enables comparator A (high trips), bit 1 enables comparator B (high trips) and bit 2 enables the fault pin (low trips). A value of 0 disables shutdown entirely.
- R3: When an enabled source trips, the pins take their safe states within the same cycle, before any clock edge.
- R4: Config bits [5:4] give the safe state of pins 1:0 and bits [7:6] give the safe state of pins 3:2. Code 00 drives low, 01 drives high, and 1x releases the pins (output enable 0, value 0).
- R5: Status bit 0, the flag, reads 1 after the third rising edge following a trip. Two of these edges are taken by the synchroniser.
- R6: With auto-restart (config bit 3) set, the flag clears on the third rising edge after the fault is removed.
- R7: With auto-restart clear, the flag stays set after the fault is gone until a status write with bit 0 = 0 clears it.
- R8: A status write is ignored while the synchronised fault (status bit 1) is active.
- R9: Once the flag has been set, the pins stay in their safe states until a rising edge that samples the period-start pulse high while the flag is already clear. A period start seen while the flag is set does not release them.
- R10: A status write with bit 0 = 1 when no fault is present sets the flag and forces the safe states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_a_trip | input | 1 | Comparator A trip, active high |
| cmp_b_trip | input | 1 | Comparator B trip, active high |
| fault_n | input | 1 | External fault pin, active low |
| period_start | input | 1 | One-cycle pulse at each PWM period boundary |
| pwm_pin_in | input | 4 | Normal PWM pin values |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = config, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| pin_out | output | 4 | Pin drive values |
| pin_oe | output | 4 | Pin output enables |

## Verification
The pin force is combinational, so the bench checks it a fraction of a nanosecond after it drives a fault, before the next edge. The flag is due on the third edge after a change in the fault, because two synchroniser stages come before the flag register. The bench samples the flag at the falling edge after the second edge, expecting the old value, and again after the third, expecting the new one. A register write, and the release of the pins on a period start, each take effect on the single edge that samples them, and the bench checks the pins just before that edge and again just after it.

// File: rtl/trip_guard_pkg.sv
`timescale 1ns/1ps
package trip_guard_pkg;
    localparam int NUM_SRC   = 3;
    localparam int NUM_PAIRS = 2;
    localparam int PAIR_PINS = 2;
    localparam int NUM_PINS  = NUM_PAIRS * PAIR_PINS;
    localparam int REG_W     = 8;

    localparam logic ADDR_CFG  = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    typedef enum logic [1:0] {
        SAFE_LOW  = 2'b00,
        SAFE_HIGH = 2'b01,
        SAFE_OFF  = 2'b10,
        SAFE_OFF2 = 2'b11
    } safe_e;

    typedef struct packed {
        logic [1:0]         pair1_safe;
        logic [1:0]         pair0_safe;
        logic               auto_restart;
        logic [NUM_SRC-1:0] src_en;
    } cfg_t;

    typedef struct packed {
        logic flag;
        logic hold;
    } latch_t;
endpackage

// File: rtl/trip_sync.sv
`timescale 1ns/1ps
module trip_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/trip_cfg_regs.sv
`timescale 1ns/1ps
module trip_cfg_regs
    import trip_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) cfg_d = cfg_t'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/trip_latch.sv
`timescale 1ns/1ps
module trip_latch
    import trip_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip_live,
    input  logic auto_restart,
    input  logic stat_wr,
    input  logic stat_flag_wdata,
    input  logic period_start,
    output logic flag,
    output logic hold
);
    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // flag: a live fault wins and also blocks any write
        if (trip_live)         st_d.flag = 1'b1;
        else if (stat_wr)      st_d.flag = stat_flag_wdata;
        else if (auto_restart) st_d.flag = 1'b0;
        // hold: follows a set flag, released only at a period boundary
        if (st_q.flag)         st_d.hold = 1'b1;
        else if (period_start) st_d.hold = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign hold = st_q.hold;
endmodule

// File: rtl/trip_pin_mux.sv
`timescale 1ns/1ps
module trip_pin_mux
    import trip_guard_pkg::*;
(
    input  logic                       force_safe,
    input  logic [NUM_PAIRS-1:0][1:0]  pair_code,
    input  logic [NUM_PINS-1:0]        pwm_in,
    output logic [NUM_PINS-1:0]        pin_out,
    output logic [NUM_PINS-1:0]        pin_oe
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int PAIR = i / PAIR_PINS;
        logic [1:0] drv; // {oe, value}

        always_comb begin
            if (!force_safe) begin
                drv = {1'b1, pwm_in[i]};
            end else begin
                case (safe_e'(pair_code[PAIR]))
                    SAFE_LOW:  drv = 2'b10;
                    SAFE_HIGH: drv = 2'b11;
                    default:   drv = 2'b00;
                endcase
            end
        end

        assign pin_out[i] = drv[0];
        assign pin_oe[i]  = drv[1];
    end
endmodule

// File: rtl/pwm_trip_guard.sv
`timescale 1ns/1ps
module pwm_trip_guard
    import trip_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_a_trip,
    input  logic                cmp_b_trip,
    input  logic                fault_n,
    input  logic                period_start,
    input  logic [NUM_PINS-1:0] pwm_pin_in,
    input  logic                reg_wr,
    input  logic                reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    logic [NUM_SRC-1:0]       trip_raw_vec;
    logic [NUM_SRC-1:0]       trip_sync_vec;
    logic                     raw_trip;
    logic                     trip_live;
    logic                     flag_q;
    logic                     hold_q;
    logic                     force_safe;
    cfg_t                     cfg_q;
    logic [NUM_PAIRS-1:0][1:0] pair_code;

    // bit 0: comparator A, bit 1: comparator B, bit 2: fault pin (low = trip)
    assign trip_raw_vec = {~fault_n, cmp_b_trip, cmp_a_trip};

    trip_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trip_raw_vec),
        .sync_out (trip_sync_vec)
    );

    trip_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr && (reg_addr == ADDR_CFG)),
        .wdata (reg_wdata),
        .cfg   (cfg_q)
    );

    assign raw_trip  = |(trip_raw_vec  & cfg_q.src_en);
    assign trip_live = |(trip_sync_vec & cfg_q.src_en);

    trip_latch u_latch (
        .clk             (clk),
        .rst_n           (rst_n),
        .trip_live       (trip_live),
        .auto_restart    (cfg_q.auto_restart),
        .stat_wr         (reg_wr && (reg_addr == ADDR_STAT)),
        .stat_flag_wdata (reg_wdata[0]),
        .period_start    (period_start),
        .flag            (flag_q),
        .hold            (hold_q)
    );

    // asynchronous path uses the raw condition; registered state keeps it
    assign force_safe = raw_trip | flag_q | hold_q;
    assign pair_code  = {cfg_q.pair1_safe, cfg_q.pair0_safe};

    trip_pin_mux u_mux (
        .force_safe (force_safe),
        .pair_code  (pair_code),
        .pwm_in     (pwm_pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    always_comb begin
        if (reg_addr == ADDR_STAT)
            reg_rdata = {{(REG_W-3){1'b0}}, hold_q, trip_live, flag_q};
        else
            reg_rdata = REG_W'(cfg_q);
    end
endmodule

// File: rtl/trip_guard_chk.sv
`timescale 1ns/1ps
module trip_guard_chk #(
    parameter int NPINS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trip_live,
    input logic             raw_trip,
    input logic             flag,
    input logic             hold,
    input logic             auto_restart,
    input logic             stat_wr,
    input logic             period_start,
    input logic [NPINS-1:0] pwm_in,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe
);
    p_passthrough_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_trip && !flag && !hold) |-> (pin_out == pwm_in && pin_oe == '1));

    p_live_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trip_live |=> flag);

    p_auto_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && auto_restart && !trip_live && !stat_wr) |=> !flag);

    p_manual_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !auto_restart && !stat_wr) |=> flag);

    p_write_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_live && stat_wr) |=> flag);

    p_hold_follows_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> hold);

    p_release_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> ($past(period_start) && !$past(flag)));
endmodule

bind pwm_trip_guard trip_guard_chk #(.NPINS(trip_guard_pkg::NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip_live    (trip_live),
    .raw_trip     (raw_trip),
    .flag         (flag_q),
    .hold         (hold_q),
    .auto_restart (cfg_q.auto_restart),
    .stat_wr      (reg_wr && (reg_addr == 1'b1)),
    .period_start (period_start),
    .pwm_in       (pwm_pin_in),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe)
);

// File: tb/tb_pwm_trip_guard.sv
`timescale 1ns/1ps
module tb_pwm_trip_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_a_trip = 1'b0, cmp_b_trip = 1'b0, fault_n = 1'b1;
    logic       period_start = 1'b0;
    logic [3:0] pwm_pin_in = 4'b0110;
    logic       reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [3:0] pin_out, pin_oe;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_trip_guard dut (
        .clk(clk), .rst_n(rst_n), .cmp_a_trip(cmp_a_trip), .cmp_b_trip(cmp_b_trip),
        .fault_n(fault_n), .period_start(period_start), .pwm_pin_in(pwm_pin_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // {oe, out} expected from the requirement encoding (R4)
    function automatic logic [7:0] exp_io(input logic [7:0] cfg, input logic [3:0] pwm, input bit forced);
        logic [3:0] o, e;
        for (int i = 0; i < 4; i++) begin
            logic [1:0] code;
            code = (i < 2) ? cfg[5:4] : cfg[7:6];
            if (!forced)      begin o[i] = pwm[i];  e[i] = 1'b1; end
            else if (code[1]) begin o[i] = 1'b0;    e[i] = 1'b0; end
            else              begin o[i] = code[0]; e[i] = 1'b1; end
        end
        return {e, o};
    endfunction

    task automatic chk_pins(input string req, input logic [7:0] cfg, input bit forced);
        #0.5;
        chk(req, {pin_oe, pin_out}, exp_io(cfg, pwm_pin_in, forced));
    endtask

    task automatic chk_flag(input string req, input logic exp);
        logic [7:0] s;
        rd(1'b1, s);
        chk(req, s[0], exp);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b0, d); chk("R1 cfg reset", d, 8'h00);
        rd(1'b1, d); chk("R1 status reset", d, 8'h00);
        chk_pins("R1 passthrough", 8'h00, 1'b0);
        pwm_pin_in = 4'b1001;
        chk_pins("R1 passthrough new pattern", 8'h00, 1'b0);
    endtask

    task automatic t_source_mask();
        logic [7:0] cfg;
        cfg = 8'b01_00_0_001;
        wr(1'b0, cfg);
        cmp_b_trip = 1'b1; fault_n = 1'b0;
        chk_pins("R2 disabled sources no force", cfg, 1'b0);
        ticks(4);
        chk_flag("R2 disabled sources no flag", 1'b0);
        chk_pins("R2 disabled sources later", cfg, 1'b0);
        cmp_b_trip = 1'b0; fault_n = 1'b1;
        cfg = 8'b01_00_0_000;
        wr(1'b0, cfg);
        cmp_a_trip = 1'b1; cmp_b_trip = 1'b1; fault_n = 1'b0;
        ticks(4);
        chk_flag("R2 no source selected", 1'b0);
        chk_pins("R2 no source selected pins", cfg, 1'b0);
        cmp_a_trip = 1'b0; cmp_b_trip = 1'b0; fault_n = 1'b1;
        ticks(3);
    endtask

    task automatic t_auto_restart();
        logic [7:0] cfg, s;
        cfg = 8'b01_00_1_001;
        wr(1'b0, cfg);
        pwm_pin_in = 4'b1010;
        cmp_a_trip = 1'b1;
        chk_pins("R3 immediate force", cfg, 1'b1);
        chk(     "R4 low/high pairs", {pin_oe, pin_out}, 8'hFC);
        ticks(2);
        chk_flag("R5 flag not yet after two edges", 1'b0);
        tick();
        chk_flag("R5 flag set on third edge", 1'b1);
        period_start = 1'b1; tick(); period_start = 1'b0;
        chk_pins("R9 period start while flagged keeps shutdown", cfg, 1'b1);
        cmp_a_trip = 1'b0;
        chk_pins("R9 force kept after raw fault drops", cfg, 1'b1);
        ticks(2);
        chk_flag("R6 flag still set two edges after removal", 1'b1);
        tick();
        chk_flag("R6 auto clear on third edge", 1'b0);
        rd(1'b1, s);
        chk("R9 hold still set", s[2], 1'b1);
        chk_pins("R9 still shut until boundary", cfg, 1'b1);
        period_start = 1'b1;
        chk_pins("R9 shut just before boundary edge", cfg, 1'b1);
        tick(); period_start = 1'b0;
        chk_pins("R9 normal after boundary", cfg, 1'b0);
    endtask

    task automatic t_manual_lock();
        logic [7:0] cfg;
        cfg = 8'b11_10_0_100;
        wr(1'b0, cfg);
        pwm_pin_in = 4'b0101;
        fault_n = 1'b0;
        chk_pins("R4 tri-state both pairs", cfg, 1'b1);
        ticks(3);
        chk_flag("R5 flag from fault pin", 1'b1);
        wr(1'b1, 8'h00);
        chk_flag("R8 write ignored while fault live", 1'b1);
        fault_n = 1'b1;
        ticks(5);
        chk_flag("R7 flag kept without auto restart", 1'b1);
        chk_pins("R7 pins still shut", cfg, 1'b1);
        wr(1'b1, 8'h00);
        chk_flag("R7 firmware clear", 1'b0);
        chk_pins("R9 shut until boundary after clear", cfg, 1'b1);
        period_start = 1'b1; tick(); period_start = 1'b0;
        chk_pins("R9 normal after boundary", cfg, 1'b0);
    endtask

    task automatic t_soft_force();
        logic [7:0] cfg;
        cfg = 8'b00_01_0_011;
        wr(1'b0, cfg);
        pwm_pin_in = 4'b1100;
        wr(1'b1, 8'h01);
        chk_flag("R10 software set", 1'b1);
        chk_pins("R10 forced outputs", cfg, 1'b1);
        chk("R10 forced value", {pin_oe, pin_out}, 8'hF3);
        wr(1'b1, 8'h00);
        chk_flag("R7 software clear", 1'b0);
        chk_pins("R9 held until boundary", cfg, 1'b1);
        period_start = 1'b1; tick(); period_start = 1'b0;
        chk_pins("R9 released", cfg, 1'b0);
    endtask

    initial begin
        ticks(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_source_mask();
        t_auto_restart();
        t_manual_lock();
        t_soft_force();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule